// File: doc/BRIEF.md
# Sequential Multi-Stage Trigger Matcher

This block watches a stream of 32-bit logic-analyzer samples and decides when a capture should begin. The host programs up to four trigger stages. Each stage has a compare mask, a compare value and a start-capture flag. The stages are checked strictly in turn. Only the stage that is currently armed is compared against each valid sample. When that stage matches, the next stage becomes armed. When the stage marked as terminal matches, the block raises a one-cycle trigger pulse. The capture controller uses this pulse to start counting post-trigger samples.

The block reports the index of the armed stage at all times. After the trigger fires, that index stays on the stage that ended the sequence. The host knows how many stages took part, and uses this count to move the reported trigger position back by that many samples.

The start-capture flag of each stage is bit 3 (value 0x08) of that stage's configuration word. The register block passes only that bit into the matcher, one bit per stage. An arm pulse or a reset restarts the sequence at stage 0.

Top module: `trig_seq_matcher`

## Requirements
- R1: A stage matches a sample when, for every bit set in that stage's mask, the sample bit equals the value bit. Sample bits whose mask bit is 0 have no effect on the result.
- R2: When the armed stage matches a valid sample and is not terminal, `stage_o` increases by one after that clock edge. A valid sample that fails to match the armed stage leaves `stage_o` unchanged, even if it matches a later stage.
- R3: A stage is terminal when its start flag (bit 3 of its configuration word, carried on `stg_start_i[i]`) is 1. When the armed terminal stage matches a valid sample, `fire_o` is 1 for exactly the one cycle that follows that clock edge.
- R4: The highest stage (index 3) is always terminal, whatever its start flag says.
- R5: When the stage-0 mask is all zero, the first valid sample after arming fires the trigger at stage 0, whatever the stage-0 start flag says.
- R6: Once the trigger has fired, later samples cause no further pulse and leave `stage_o` unchanged, until the next arm or reset.
- R7: A reset, or an `arm_i` high at a clock edge, sets `stage_o` to 0 with `fire_o` low. `arm_i` takes priority over a sample presented in the same cycle.
- R8: A sample with `smp_valid_i` low has no effect on `stage_o` or `fire_o`.
- R9: In the cycle in which `fire_o` is high, `stage_o` equals the index of the terminal stage that matched. This index is the number of stages used minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Restart the stage sequence at stage 0 |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 32 | Sample word |
| stg_mask_i | input | 128 | Per-stage compare masks; stage i occupies bits [32i+31:32i] |
| stg_value_i | input | 128 | Per-stage compare values; same packing as the masks |
| stg_start_i | input | 4 | Per-stage start-capture flag (bit 3 of each configuration word) |
| stage_o | output | 2 | Index of the armed stage, or of the stage that fired |
| fire_o | output | 1 | One-cycle trigger pulse |

## Verification
An internal state that is wrong shows up at the ports one cycle after the sample that exposed it. A stage counter that skips or stalls makes `stage_o` differ on the very next edge. A wrong terminal decision either leaves `fire_o` low at that edge, or makes `stage_o` move past the stage where it should have stopped. A done flag that fails to latch shows up as a second pulse on the next sample that matches. The bench compares both outputs after every clock against a model built from the requirements. It uses directed sequences for don't-care bits, out-of-order matches, the all-zero stage-0 mask, the highest stage with no flag, and arm colliding with a sample. It then runs a long seeded random sequence whose samples are biased toward matching the armed stage.

// File: rtl/trig_pkg.sv
package trig_pkg;

    // Default geometry of the matcher
    localparam int unsigned DEF_STAGES = 4;
    localparam int unsigned DEF_SMP_W  = 32;

    // Bit of a stage configuration word that carries the start-capture flag
    localparam int unsigned START_FLAG_BIT = 3;

    // Sequencer state: hunting through stages, or finished until re-armed
    typedef enum logic {
        SEQ_HUNT = 1'b0,
        SEQ_DONE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/trig_stage_eval.sv
module trig_stage_eval #(
    parameter int unsigned SMP_W    = 32,
    parameter int unsigned STAGE_ID = 0,
    parameter int unsigned LAST_ID  = 3
) (
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] mask_i,
    input  logic [SMP_W-1:0] value_i,
    input  logic             start_i,
    output logic             hit_o,
    output logic             term_o
);

    // A bit mismatches only where the mask cares about it
    logic [SMP_W-1:0] diff;
    assign diff  = (smp_i ^ value_i) & mask_i;
    assign hit_o = (diff == '0);

    // Terminal-stage rule depends on the position in the chain
    generate
        if (STAGE_ID == LAST_ID) begin : g_last
            assign term_o = 1'b1;
        end else if (STAGE_ID == 0) begin : g_first
            assign term_o = start_i | (mask_i == '0);
        end else begin : g_mid
            assign term_o = start_i;
        end
    endgenerate

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
    import trig_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 4,
    localparam int unsigned IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             smp_valid_i,
    input  logic             hit_i,
    input  logic             term_i,
    output logic [IDX_W-1:0] stage_o,
    output logic             fire_o
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] stage_q;
    logic             fire_q;
    logic             take;

    assign take = (state_q == SEQ_HUNT) && smp_valid_i && hit_i;

    always_ff @(posedge clk) begin
        if (rst || arm_i) begin
            state_q <= SEQ_HUNT;
            stage_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (take) begin
                if (term_i) begin
                    state_q <= SEQ_DONE;
                    fire_q  <= 1'b1;
                end else begin
                    stage_q <= stage_q + IDX_W'(1);
                end
            end
        end
    end

    assign stage_o = stage_q;
    assign fire_o  = fire_q;

    // R3: trigger is a single-cycle pulse
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    // R3: a pulse is only produced by a valid, matching, terminal sample
    p_pulse_cause_r3: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past(smp_valid_i && hit_i && term_i && !arm_i));

    // R7: arm returns to stage 0 with no pulse
    p_arm_restart_r7: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (stage_q == '0 && !fire_q));

    // R8: without a valid sample nothing moves
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!arm_i && !smp_valid_i) |=> ($stable(stage_q) && !fire_q));

    // R2: the stage index advances by at most one per sample
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> (stage_q == $past(stage_q) ||
                    stage_q == $past(stage_q) + IDX_W'(1)));

    // R6: after firing, the sequencer stays quiet until re-armed
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DONE && !arm_i) |=> (!fire_q && $stable(stage_q)));

endmodule

// File: rtl/trig_seq_matcher.sv
module trig_seq_matcher
    import trig_pkg::*;
#(
    parameter int unsigned NUM_STAGES = DEF_STAGES,
    parameter int unsigned SMP_W      = DEF_SMP_W,
    localparam int unsigned IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
    localparam int unsigned BUS_W = NUM_STAGES * SMP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm_i,
    input  logic                  smp_valid_i,
    input  logic [SMP_W-1:0]      smp_data_i,
    input  logic [BUS_W-1:0]      stg_mask_i,
    input  logic [BUS_W-1:0]      stg_value_i,
    input  logic [NUM_STAGES-1:0] stg_start_i,
    output logic [IDX_W-1:0]      stage_o,
    output logic                  fire_o
);

    logic [NUM_STAGES-1:0] hit_vec;
    logic [NUM_STAGES-1:0] term_vec;
    logic                  hit_sel;
    logic                  term_sel;

    generate
        for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
            trig_stage_eval #(
                .SMP_W    (SMP_W),
                .STAGE_ID (gi),
                .LAST_ID  (NUM_STAGES - 1)
            ) u_eval (
                .smp_i   (smp_data_i),
                .mask_i  (stg_mask_i[gi*SMP_W +: SMP_W]),
                .value_i (stg_value_i[gi*SMP_W +: SMP_W]),
                .start_i (stg_start_i[gi]),
                .hit_o   (hit_vec[gi]),
                .term_o  (term_vec[gi])
            );
        end
    endgenerate

    // Only the armed stage is looked at
    always_comb begin
        hit_sel  = 1'b0;
        term_sel = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (stage_o == IDX_W'(i)) begin
                hit_sel  = hit_vec[i];
                term_sel = term_vec[i];
            end
        end
    end

    trig_seq_ctrl #(
        .NUM_STAGES (NUM_STAGES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .smp_valid_i (smp_valid_i),
        .hit_i       (hit_sel),
        .term_i      (term_sel),
        .stage_o     (stage_o),
        .fire_o      (fire_o)
    );

    // R4: a valid match on the highest stage always ends the sequence
    p_last_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (stage_o == IDX_W'(NUM_STAGES - 1) && smp_valid_i && hit_vec[NUM_STAGES-1]
         && !arm_i && !fire_o) |=> (stage_o == IDX_W'(NUM_STAGES - 1)));

endmodule

// File: tb/trig_seq_matcher_tb.sv
`timescale 1ns/1ps
module trig_seq_matcher_tb_top;

    localparam int NS = 4;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic          vld = 1'b0;
    logic [W-1:0]  dat = '0;
    logic [W-1:0]  bm [NS];
    logic [W-1:0]  bv [NS];
    logic [NS-1:0] bs;
    logic [NS*W-1:0] mask_bus, value_bus;
    logic [1:0]    stage;
    logic          fire;

    int checks = 0;
    int errors = 0;

    // model state
    int  m_stage = 0;
    bit  m_done  = 0;
    bit  m_fire  = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            mask_bus[i*W +: W]  = bm[i];
            value_bus[i*W +: W] = bv[i];
        end
    end

    trig_seq_matcher dut_i (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .smp_valid_i (vld),
        .smp_data_i  (dat),
        .stg_mask_i  (mask_bus),
        .stg_value_i (value_bus),
        .stg_start_i (bs),
        .stage_o     (stage),
        .fire_o      (fire)
    );

    function automatic bit ref_hit(input logic [W-1:0] s, input int k);
        return ((s ^ bv[k]) & bm[k]) == '0;
    endfunction

    function automatic bit ref_term(input int k);
        return bs[k] || (k == NS - 1) || (k == 0 && bm[0] == '0);
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // drive one cycle, advance model, compare after the edge
    task automatic step(input bit a, input bit v, input logic [W-1:0] d, input string req);
        @(negedge clk);
        arm = a; vld = v; dat = d;
        m_fire = 0;
        if (a) begin
            m_stage = 0; m_done = 0;
        end else if (!m_done && v && ref_hit(d, m_stage)) begin
            if (ref_term(m_stage)) begin
                m_done = 1; m_fire = 1;
            end else begin
                m_stage++;
            end
        end
        @(posedge clk);
        #1;
        check(req, int'(stage), m_stage, "stage");
        check(req, int'(fire), int'(m_fire), "fire");
    endtask

    task automatic cfg_clear();
        for (int i = 0; i < NS; i++) begin
            bm[i] = '1; bv[i] = '0;
        end
        bs = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] s;
        int unsigned seed;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        cfg_clear();

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #1;
        check("R7", int'(stage), 0, "reset stage");
        check("R7", int'(fire), 0, "reset fire");

        // three-stage sequence, stage 2 terminal
        bm[0] = 32'h0000_00FF; bv[0] = 32'h0000_0012;
        bm[1] = 32'h0000_FF00; bv[1] = 32'h0000_3400;
        bm[2] = 32'h8000_0000; bv[2] = 32'h8000_0000;
        bs = 4'b0100;
        step(0, 1, 32'h0000_0013, "R1");   // mismatch
        step(0, 0, 32'h0000_0012, "R8");   // invalid
        step(0, 1, 32'h0000_3400, "R2");   // matches a later stage only
        step(0, 1, 32'hABCD_AB12, "R1");   // don't-care bits differ
        step(0, 1, 32'h8000_0000, "R2");   // stage 2 pattern while at 1
        step(0, 1, 32'h0000_3400, "R2");
        step(0, 0, 32'h8000_0000, "R8");
        step(0, 1, 32'h8000_0001, "R3");   // fires; stage 2 -> R9
        check("R9", int'(stage), 2, "stage at fire");
        step(0, 1, 32'h8000_0001, "R6");
        step(0, 1, 32'h0000_0012, "R6");
        step(1, 0, 32'h0, "R7");
        step(0, 1, 32'h0000_0012, "R2");
        step(1, 1, 32'h0000_3400, "R7");   // arm beats a matching sample

        // highest stage without flag
        step(1, 0, 32'h0, "R7");
        for (int i = 0; i < NS; i++) begin
            bm[i] = 32'h0000_000F; bv[i] = 32'(i + 1);
        end
        bs = '0;
        for (int i = 0; i < NS; i++) step(0, 1, 32'(i + 1), "R4");
        check("R4", int'(stage), 3, "last stage index");
        step(0, 1, 32'h0000_0004, "R6");

        // stage-0 mask zero: immediate trigger
        step(1, 0, 32'h0, "R7");
        bm[0] = '0; bv[0] = 32'hFFFF_FFFF; bs = '0;
        step(0, 0, 32'h1234_5678, "R8");
        step(0, 1, 32'h1234_5678, "R5");
        check("R5", int'(stage), 0, "fired at stage 0");

        // seeded random
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < NS; i++) begin
                bm[i] = $urandom() & $urandom() & $urandom() & $urandom();
                bv[i] = $urandom();
            end
            bs = 4'($urandom());
            step(1, 0, 32'h0, "R7");
            for (int n = 0; n < 60; n++) begin
                s = $urandom();
                if ($urandom_range(0, 1) == 1)
                    s = (s & ~bm[m_stage]) | (bv[m_stage] & bm[m_stage]);
                step(($urandom_range(0, 49) == 0), ($urandom_range(0, 3) != 0), s, "R2");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule